// File: doc/BRIEF.md
# Reset Time-out Sequencer

This block generates the two active-low reset outputs of a supervisory circuit. A synchronized supply-good flag from an external voltage comparator drives it, together with a periodic reset-tick pulse from a slow timebase and a fault request from a watchdog block. The block holds reset while the supply is low. After the supply recovers, it waits through a fixed initialization delay. It then counts reset ticks and releases reset only after a fixed number of them has arrived.

There are two reset outputs. The supply-only reset follows voltage events alone. The combined reset also drops on a watchdog fault and stays low for one full tick time-out before it releases. Every release is marked by a one-clock strobe, which the watchdog block uses to sample its own enable and mode settings.

Top module: `rst_seq`

## Requirements
- R1: While `por_n` is low, `sup_rst_n` and `sys_rst_n` are 0 and `release_stb` is 0.
- R2: No tick is counted on the first clock edge that samples `supply_ok` high, nor on the `INIT_CYCLES` edges that follow it. Ticks in that window have no effect.
- R3: After the initialization delay, both reset outputs stay 0 until `RELEASE_TICKS` (default 4) tick pulses have been sampled. Both go to 1 right after the edge that samples the last of those ticks.
- R4: When `supply_ok` is 0, both reset outputs are 0 in the same cycle, whatever the value of `wdt_fault`.
- R5: `sup_rst_n` does not respond to `wdt_fault`. It stays 1 through a watchdog-fault time-out.
- R6: When `wdt_fault` is sampled high while reset is released, `sys_rst_n` goes to 0 after that edge. It returns to 1 after `RELEASE_TICKS` further ticks, with no initialization delay.
- R7: If `supply_ok` falls while ticks are being counted, during either power-up or a fault time-out, any partial count is discarded. After recovery, the full initialization delay and all `RELEASE_TICKS` ticks are needed again.
- R8: `release_stb` is a single-cycle pulse. It is high in exactly the first cycle of each release, following the edge that samples the final tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| supply_ok | input | 1 | Synchronized supply-good flag |
| tick | input | 1 | One-cycle reset-tick pulse |
| wdt_fault | input | 1 | Watchdog fault request |
| sup_rst_n | output | 1 | Supply-only reset, active low |
| sys_rst_n | output | 1 | Combined supply and watchdog reset, active low |
| release_stb | output | 1 | One-cycle strobe at each reset release |

## Verification
A low supply reaches both outputs combinationally, so the bench checks that case 1 ns after driving the input, before any clock edge. Inputs change on falling edges, and each tick pulse is sampled on the next rising edge. For the pulse that completes a sequence, the driver computes that edge number in advance and pushes it to the scoreboard. The monitor then expects `release_stb` on the falling edge right after that edge, with the reset levels already high. Output levels are checked one full cycle after a stimulus edge, where a fault or a tick has already taken effect.

// File: rtl/rst_seq.sv
module rst_seq #(
  parameter int INIT_CYCLES   = 64,
  parameter int RELEASE_TICKS = 4
) (
  input  logic clk,
  input  logic por_n,
  input  logic supply_ok,
  input  logic tick,
  input  logic wdt_fault,
  output logic sup_rst_n,
  output logic sys_rst_n,
  output logic release_stb
);

  localparam int IW = (INIT_CYCLES > 1) ? $clog2(INIT_CYCLES) : 1;
  localparam int TW = (RELEASE_TICKS > 1) ? $clog2(RELEASE_TICKS) : 1;
  localparam logic [IW-1:0] INIT_LAST = IW'(INIT_CYCLES - 1);
  localparam logic [TW-1:0] TICK_LAST = TW'(RELEASE_TICKS - 1);

  typedef enum logic [2:0] {
    S_HOLD  = 3'd0,
    S_INIT  = 3'd1,
    S_COUNT = 3'd2,
    S_RUN   = 3'd3,
    S_FAULT = 3'd4
  } state_t;

  state_t         state;
  logic [IW-1:0]  init_cnt;
  logic [TW-1:0]  tick_cnt;
  logic           counting;

  assign counting = (state == S_COUNT) || (state == S_FAULT);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state       <= S_HOLD;
      init_cnt    <= '0;
      tick_cnt    <= '0;
      release_stb <= 1'b0;
    end else begin
      release_stb <= 1'b0;
      if (!supply_ok) begin
        state    <= S_HOLD;
        init_cnt <= '0;
        tick_cnt <= '0;
      end else begin
        case (state)
          S_HOLD: begin
            state    <= S_INIT;
            init_cnt <= '0;
            tick_cnt <= '0;
          end
          S_INIT: begin
            if (init_cnt == INIT_LAST) state <= S_COUNT;
            else init_cnt <= init_cnt + 1'b1;
          end
          S_RUN: begin
            tick_cnt <= '0;
            if (wdt_fault) state <= S_FAULT;
          end
          default: begin
            if (counting && tick) begin
              if (tick_cnt == TICK_LAST) begin
                state       <= S_RUN;
                tick_cnt    <= '0;
                release_stb <= 1'b1;
              end else begin
                tick_cnt <= tick_cnt + 1'b1;
              end
            end
          end
        endcase
      end
    end
  end

  assign sup_rst_n = supply_ok && ((state == S_RUN) || (state == S_FAULT));
  assign sys_rst_n = supply_ok && (state == S_RUN);

endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk (
  input logic clk,
  input logic por_n,
  input logic supply_ok,
  input logic tick,
  input logic wdt_fault,
  input logic sup_rst_n,
  input logic sys_rst_n,
  input logic release_stb
);

  a_r4_low_supply: assert property (@(posedge clk) disable iff (!por_n)
    !supply_ok |-> (!sup_rst_n && !sys_rst_n));

  a_r5_sys_under_sup: assert property (@(posedge clk) disable iff (!por_n)
    sys_rst_n |-> sup_rst_n);

  a_r6_fault_drops: assert property (@(posedge clk) disable iff (!por_n)
    (sys_rst_n && wdt_fault) |=> !sys_rst_n);

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!por_n)
    release_stb |=> !release_stb);

  a_r8_stb_at_release: assert property (@(posedge clk) disable iff (!por_n)
    (release_stb && supply_ok) |-> sys_rst_n);

  a_r3_stb_needs_tick: assert property (@(posedge clk) disable iff (!por_n)
    release_stb |-> $past(tick));

endmodule

bind rst_seq rst_seq_chk u_chk (
  .clk(clk), .por_n(por_n), .supply_ok(supply_ok), .tick(tick),
  .wdt_fault(wdt_fault), .sup_rst_n(sup_rst_n), .sys_rst_n(sys_rst_n),
  .release_stb(release_stb)
);

// File: tb/rst_seq_tb.sv
`timescale 1ns/1ps
module rst_seq_tb;
  localparam int INIT = 6;
  localparam int NT   = 4;

  logic clk = 1'b0, por_n = 1'b0, supply_ok = 1'b0, tick = 1'b0, wdt_fault = 1'b0;
  logic sup_rst_n, sys_rst_n, release_stb;
  int total = 0, bad = 0, cyc = 0;
  int exp_q[$];
  bit done = 0;

  rst_seq #(.INIT_CYCLES(INIT), .RELEASE_TICKS(NT)) u_dut (
    .clk(clk), .por_n(por_n), .supply_ok(supply_ok), .tick(tick),
    .wdt_fault(wdt_fault), .sup_rst_n(sup_rst_n), .sys_rst_n(sys_rst_n),
    .release_stb(release_stb)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string req, string what, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_ticks(int n, bit rel);
    if (rel) exp_q.push_back(cyc + 2*n - 1);
    repeat (n) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      @(negedge clk);
    end
  endtask

  always @(negedge clk) begin
    if (por_n && release_stb) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R8 unexpected strobe actual=%0d expected=none", cyc);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (e != cyc) begin
          bad++;
          $display("FAIL R8 strobe cycle actual=%0d expected=%0d", cyc, e);
        end
      end
    end
  end

  initial begin
    @(negedge clk);
    step(2);
    chk("R1", "sup_rst_n", sup_rst_n, 1'b0);
    chk("R1", "sys_rst_n", sys_rst_n, 1'b0);
    chk("R1", "release_stb", release_stb, 1'b0);
    por_n = 1'b1;
    step(1);

    // R2: ticks inside the init window are ignored
    supply_ok = 1'b1;
    step(1);
    pulse_ticks(2, 0);
    step(2);
    pulse_ticks(3, 0);
    chk("R2", "sys_rst_n after 3 counted", sys_rst_n, 1'b0);
    chk("R3", "sup_rst_n before last tick", sup_rst_n, 1'b0);
    pulse_ticks(1, 1);
    chk("R3", "sup_rst_n released", sup_rst_n, 1'b1);
    chk("R3", "sys_rst_n released", sys_rst_n, 1'b1);
    chk("R8", "strobe one cycle", release_stb, 1'b0);

    // R5 / R6: watchdog fault time-out
    wdt_fault = 1'b1;
    step(1);
    wdt_fault = 1'b0;
    chk("R6", "sys_rst_n on fault", sys_rst_n, 1'b0);
    chk("R5", "sup_rst_n on fault", sup_rst_n, 1'b1);
    pulse_ticks(3, 0);
    chk("R6", "sys_rst_n after 3 ticks", sys_rst_n, 1'b0);
    chk("R5", "sup_rst_n during fault", sup_rst_n, 1'b1);
    pulse_ticks(1, 1);
    chk("R6", "sys_rst_n after fault time-out", sys_rst_n, 1'b1);

    // R4: low supply forces both outputs low at once
    supply_ok = 1'b0;
    wdt_fault = 1'b1;
    #1;
    chk("R4", "sup_rst_n low supply", sup_rst_n, 1'b0);
    chk("R4", "sys_rst_n low supply", sys_rst_n, 1'b0);
    wdt_fault = 1'b0;
    step(1);

    // R7: drop during power-up count
    supply_ok = 1'b1;
    step(INIT + 1);
    pulse_ticks(2, 0);
    supply_ok = 1'b0;
    step(2);
    supply_ok = 1'b1;
    step(INIT + 1);
    pulse_ticks(3, 0);
    chk("R7", "sys_rst_n partial count discarded", sys_rst_n, 1'b0);
    pulse_ticks(1, 1);
    chk("R7", "sys_rst_n after restart", sys_rst_n, 1'b1);
    chk("R7", "sup_rst_n after restart", sup_rst_n, 1'b1);

    // R7: drop during fault time-out
    wdt_fault = 1'b1;
    step(1);
    wdt_fault = 1'b0;
    pulse_ticks(2, 0);
    supply_ok = 1'b0;
    step(2);
    supply_ok = 1'b1;
    chk("R7", "sup_rst_n after drop in fault", sup_rst_n, 1'b0);
    step(INIT + 1);
    pulse_ticks(3, 0);
    chk("R7", "sup_rst_n needs full count", sup_rst_n, 1'b0);
    pulse_ticks(1, 1);
    chk("R7", "sup_rst_n released", sup_rst_n, 1'b1);
    chk("R7", "sys_rst_n released", sys_rst_n, 1'b1);

    step(3);
    chk("R8", "all strobes seen", exp_q.size() == 0, 1'b1);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule